// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt Unit

This unit watches the live calendar time and compares it with a programmed alarm time. It raises an interrupt when they agree. The calendar has seven fields: year, month, day of month, weekday, hour, minute and second. Each field has its own compare enable, so an alarm can fire daily, hourly, on one weekday, or once at a single instant. A field whose enable is clear plays no part in the decision.

A single arm input gates the whole comparison. The unit reports whether the comparison is armed through a status output, which follows the arm input two cycles later. Software must leave the alarm fields and the field enables alone while the arm input is high.

The interrupt path has three terms. The raw flag marks a current match. It is masked by an interrupt enable and can be forced on by a force input. The result is the status output, which is registered once more to drive the interrupt line. Counting the calendar and decoding bus accesses are done elsewhere.

Top module: `rtc_alarm_match_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `match_armed`, `irq_raw` and `irq` are 0.
- R2: `match_armed` equals the value `match_en` had two clock edges earlier, on both rising and falling transitions.
- R3: `irq_raw` is 0 in any cycle that follows a cycle in which `match_armed` was 0, whatever the field values.
- R4: When armed and every enabled field equals its live field, `irq_raw` is 1 after the next clock edge. It stays 1 for as long as the condition holds.
- R5: `fld_en` bit order is bit 0 second, bit 1 minute, bit 2 hour, bit 3 weekday, bit 4 day of month, bit 5 month, bit 6 year. A field whose bit is 0 is ignored: a difference in that field does not clear `irq_raw`.
- R6: A difference in any enabled field makes `irq_raw` 0 after the next clock edge.
- R7: With `fld_en` all zero, `irq_raw` is 1 in every cycle once armed, so every second of the calendar matches.
- R8: `irq_status` equals (`irq_raw` AND `int_en`) OR `int_force`, combinationally in the same cycle.
- R9: `irq` is `irq_status` delayed by one clock edge and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| live_year | input | 12 | Current year |
| live_month | input | 4 | Current month, 1..12 |
| live_day | input | 5 | Current day of month, 1..31 |
| live_wday | input | 3 | Current weekday, 0 Sunday to 6 Saturday |
| live_hour | input | 5 | Current hour |
| live_min | input | 6 | Current minute |
| live_sec | input | 6 | Current second |
| alm_year | input | 12 | Alarm year |
| alm_month | input | 4 | Alarm month |
| alm_day | input | 5 | Alarm day of month |
| alm_wday | input | 3 | Alarm weekday |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| fld_en | input | 7 | Per-field compare enables (order in R5) |
| match_en | input | 1 | Arm input for the comparison |
| int_en | input | 1 | Interrupt enable mask |
| int_force | input | 1 | Interrupt force |
| match_armed | output | 1 | Armed status, delayed copy of `match_en` |
| irq_raw | output | 1 | Raw match interrupt |
| irq_status | output | 1 | Masked and forced interrupt status |
| irq | output | 1 | Registered interrupt line |

## Verification
A fault in the arming pipeline shows at `match_armed` one or two cycles too early or too late after `match_en` toggles. It also shows as `irq_raw` appearing while disarmed. A swapped or dropped field enable shows within one cycle as `irq_raw` taking the wrong value. The bench exposes this by sweeping all 128 enable patterns against a mismatch in each single field. A fault in the mask, force or output register shows at `irq_status` in the same cycle, or at `irq` one edge later, across all eight raw/enable/force combinations.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int YEAR_W  = 12;
    localparam int MON_W   = 4;
    localparam int DAY_W   = 5;
    localparam int WDAY_W  = 3;
    localparam int HOUR_W  = 5;
    localparam int MIN_W   = 6;
    localparam int SEC_W   = 6;
    localparam int NFIELDS = 7;
    localparam int ARM_LAT = 2;

    // Field enable bit positions
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_WDAY  = 3;
    localparam int F_DAY   = 4;
    localparam int F_MON   = 5;
    localparam int F_YEAR  = 6;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
        logic [WDAY_W-1:0] wday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  cal_t               live_i,
    input  cal_t               alarm_i,
    input  logic [NFIELDS-1:0] fld_en_i,
    output logic               match_o
);
    logic [NFIELDS-1:0] eq;
    logic [NFIELDS-1:0] hit;

    always_comb begin
        eq         = '0;
        eq[F_SEC]  = (live_i.sec   == alarm_i.sec);
        eq[F_MIN]  = (live_i.min   == alarm_i.min);
        eq[F_HOUR] = (live_i.hour  == alarm_i.hour);
        eq[F_WDAY] = (live_i.wday  == alarm_i.wday);
        eq[F_DAY]  = (live_i.day   == alarm_i.day);
        eq[F_MON]  = (live_i.month == alarm_i.month);
        eq[F_YEAR] = (live_i.year  == alarm_i.year);
    end

    // a disabled field always counts as a hit
    for (genvar i = 0; i < NFIELDS; i++) begin : g_hit
        assign hit[i] = ~fld_en_i[i] | eq[i];
    end

    assign match_o = &hit;
endmodule

// File: rtl/rtc_alarm_arm.sv
module rtc_alarm_arm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_en_i,
    output logic armed_o
);
    typedef struct packed {
        logic [ARM_LAT-1:0] pipe;
    } arm_state_t;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe = {st_q.pipe[ARM_LAT-2:0], match_en_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.pipe[ARM_LAT-1];
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic match_i,
    input  logic int_en_i,
    input  logic int_force_i,
    output logic raw_o,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic raw;
        logic irq;
        logic ran;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       status;

    always_comb begin
        status     = (st_q.raw & int_en_i) | int_force_i;
        st_d       = st_q;
        st_d.raw   = armed_i & match_i;
        st_d.irq   = status;
        st_d.ran   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign status_o = status;
    assign irq_o    = st_q.irq;

    // R3
    no_raw_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> !raw_o);
    // R6
    mismatch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !match_i) |=> !raw_o);
    // R8
    force_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_force_i |-> status_o);
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ran |-> (irq_o == $past(status_o)));
endmodule

// File: rtl/rtc_alarm_match_unit.sv
module rtc_alarm_match_unit
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [YEAR_W-1:0]  live_year,
    input  logic [MON_W-1:0]   live_month,
    input  logic [DAY_W-1:0]   live_day,
    input  logic [WDAY_W-1:0]  live_wday,
    input  logic [HOUR_W-1:0]  live_hour,
    input  logic [MIN_W-1:0]   live_min,
    input  logic [SEC_W-1:0]   live_sec,
    input  logic [YEAR_W-1:0]  alm_year,
    input  logic [MON_W-1:0]   alm_month,
    input  logic [DAY_W-1:0]   alm_day,
    input  logic [WDAY_W-1:0]  alm_wday,
    input  logic [HOUR_W-1:0]  alm_hour,
    input  logic [MIN_W-1:0]   alm_min,
    input  logic [SEC_W-1:0]   alm_sec,
    input  logic [NFIELDS-1:0] fld_en,
    input  logic               match_en,
    input  logic               int_en,
    input  logic               int_force,
    output logic               match_armed,
    output logic               irq_raw,
    output logic               irq_status,
    output logic               irq
);
    cal_t live, alarm;
    logic match;

    assign live  = '{year: live_year, month: live_month, day: live_day, wday: live_wday,
                     hour: live_hour, min: live_min, sec: live_sec};
    assign alarm = '{year: alm_year, month: alm_month, day: alm_day, wday: alm_wday,
                     hour: alm_hour, min: alm_min, sec: alm_sec};

    rtc_alarm_cmp u_cmp (
        .live_i   (live),
        .alarm_i  (alarm),
        .fld_en_i (fld_en),
        .match_o  (match)
    );

    rtc_alarm_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_en_i (match_en),
        .armed_o    (match_armed)
    );

    rtc_alarm_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed_i     (match_armed),
        .match_i     (match),
        .int_en_i    (int_en),
        .int_force_i (int_force),
        .raw_o       (irq_raw),
        .status_o    (irq_status),
        .irq_o       (irq)
    );

    // cycles since reset, saturating, for the delay check
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R2
    arm_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (match_armed == $past(match_en, 2)));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (!match_armed && !irq_raw && !irq));
endmodule

// File: tb/rtc_alarm_match_unit_tb.sv
module rtc_alarm_match_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] l_year, a_year;
    logic [3:0]  l_mon,  a_mon;
    logic [4:0]  l_day,  a_day;
    logic [2:0]  l_wday, a_wday;
    logic [4:0]  l_hour, a_hour;
    logic [5:0]  l_min,  a_min;
    logic [5:0]  l_sec,  a_sec;
    logic [6:0]  fld_en;
    logic        match_en, int_en, int_force;
    logic        match_armed, irq_raw, irq_status, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rtc_alarm_match_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .live_year(l_year), .live_month(l_mon), .live_day(l_day), .live_wday(l_wday),
        .live_hour(l_hour), .live_min(l_min), .live_sec(l_sec),
        .alm_year(a_year), .alm_month(a_mon), .alm_day(a_day), .alm_wday(a_wday),
        .alm_hour(a_hour), .alm_min(a_min), .alm_sec(a_sec),
        .fld_en(fld_en), .match_en(match_en), .int_en(int_en), .int_force(int_force),
        .match_armed(match_armed), .irq_raw(irq_raw), .irq_status(irq_status), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic alarm_equal();
        a_year = l_year; a_mon = l_mon; a_day = l_day; a_wday = l_wday;
        a_hour = l_hour; a_min = l_min; a_sec = l_sec;
    endtask

    // flip the low bit of alarm field at enable position f (R5 bit order)
    task automatic alarm_spoil(input int f);
        case (f)
            0: a_sec  = l_sec  ^ 6'd1;
            1: a_min  = l_min  ^ 6'd1;
            2: a_hour = l_hour ^ 5'd1;
            3: a_wday = l_wday ^ 3'd1;
            4: a_day  = l_day  ^ 5'd1;
            5: a_mon  = l_mon  ^ 4'd1;
            default: a_year = l_year ^ 12'd1;
        endcase
    endtask

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        l_year = 12'd2024; l_mon = 4'd2; l_day = 5'd29; l_wday = 3'd4;
        l_hour = 5'd13; l_min = 6'd45; l_sec = 6'd30;
        alarm_equal();
        fld_en = 7'h7F; match_en = 1'b1; int_en = 1'b1; int_force = 1'b0;

        // R1: reset state, even with a full match and arm requested
        step(); step();
        check("R1 armed in reset", match_armed, 1'b0);
        check("R1 raw in reset", irq_raw, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        check("R1 status in reset", irq_status, 1'b0);
        match_en = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1 armed after reset", match_armed, 1'b0);
        check("R1 raw after reset", irq_raw, 1'b0);

        // R3: full match while disarmed
        step(); step();
        check("R3 raw disarmed", irq_raw, 1'b0);

        // R2: rising
        match_en = 1'b1;
        step();
        check("R2 armed after 1 edge", match_armed, 1'b0);
        check("R3 raw before armed", irq_raw, 1'b0);
        step();
        check("R2 armed after 2 edges", match_armed, 1'b1);
        check("R3 raw same cycle as arm", irq_raw, 1'b0);
        step();
        check("R4 raw after armed", irq_raw, 1'b1);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R4 raw holds", irq_raw, 1'b1);
        end

        // R4/R5/R6: all enable patterns against each single-field mismatch
        for (int en = 0; en < 128; en++) begin
            for (int f = -1; f < 7; f++) begin
                fld_en = en[6:0];
                alarm_equal();
                if (f >= 0) alarm_spoil(f);
                step();
                if (f < 0)
                    check("R4 full match", irq_raw, 1'b1);
                else if (en[f])
                    check("R6 enabled mismatch", irq_raw, 1'b0);
                else
                    check("R5 disabled field ignored", irq_raw, 1'b1);
            end
        end

        // R7: no enables, every field differs, many seconds
        fld_en = 7'h00;
        for (int f = 0; f < 7; f++) alarm_spoil(f);
        for (int s = 0; s < 60; s++) begin
            l_sec = s[5:0];
            step();
            check("R7 every second matches", irq_raw, 1'b1);
        end
        l_sec = 6'd30;

        // R8/R9: raw x enable x force
        fld_en = 7'h01;
        for (int r = 0; r < 2; r++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int fo = 0; fo < 2; fo++) begin
                    logic exp_s;
                    alarm_equal();
                    if (r == 0) alarm_spoil(0);
                    int_en = ie[0]; int_force = fo[0];
                    step();
                    exp_s = (r[0] & ie[0]) | fo[0];
                    check("R4 raw setup", irq_raw, r[0]);
                    check("R8 status", irq_status, exp_s);
                    step();
                    check("R9 irq delayed status", irq, exp_s);
                end
            end
        end
        int_force = 1'b0; int_en = 1'b1;

        // R2 falling, R3 no raw once disarmed
        alarm_equal();
        step();
        check("R4 raw before disarm", irq_raw, 1'b1);
        match_en = 1'b0;
        step();
        check("R2 armed 1 edge after drop", match_armed, 1'b1);
        step();
        check("R2 armed 2 edges after drop", match_armed, 1'b0);
        step();
        check("R3 raw after disarm", irq_raw, 1'b0);
        step();
        check("R9 irq after disarm", irq, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule